// File: doc/BRIEF.md
# Per-Context Watchdog Timeout Counter

This block is the hang detector for one engine of a command processor that runs work from several contexts in turn. Software sets an enable bit and a threshold through a small register write port. While the watchdog is enabled, an elapsed-work counter advances by one on every cycle in which the tick input is high and the engine is not idle. When the counter reaches the threshold, the block raises a one-cycle timeout interrupt and sets a sticky status bit. Software clears that bit by writing a one to it.

The enable and threshold settings belong to the running context. At a context switch, the outgoing values are visible on the save outputs, and the incoming values are taken from the restore inputs. The running count is never saved. Every switch zeroes it and turns the watchdog off, unless restored settings turn it back on. A context that is preempted and later resubmitted therefore gets its full threshold again.

Top module: `ctx_watchdog`

## Requirements
- R1: After reset the count, the enable, the threshold, the status bit and the interrupt are all zero.
- R2: With the watchdog enabled and a nonzero threshold, the count rises by exactly one after each clock edge at which `tick_en_i` is high and `engine_idle_i` is low. Otherwise it holds.
- R3: While `engine_idle_i` is high, the count does not change, even when ticks are present.
- R4: On the edge where the count becomes equal to the threshold, `irq_o` goes high for exactly one cycle and `timeout_status_o` becomes 1.
- R5: Once the count equals the threshold it stays there, and further ticks produce no further interrupt.
- R6: A threshold of zero disables timeouts. The count stays at zero and no interrupt is raised, even while the watchdog is enabled.
- R7: A register write to address 2 with data bit 0 set clears the status bit. Writing 0 there has no effect. If an expiry and a clear land in the same cycle, the status bit ends set.
- R8: A context switch (`ctx_switch_i` high) zeroes the count. When no restore accompanies it (`ctx_restore_valid_i` low), the enable is cleared and the threshold is kept. Ticks then leave the count at zero until software writes enable bit 0 at address 0.
- R9: While `ctx_switch_i` is high, `save_enable_o` and `save_thresh_o` show the outgoing context's settings. A switch with `ctx_restore_valid_i` high loads enable and threshold from `ctx_restore_enable_i` and `ctx_restore_thresh_i`.
- R10: A register write to address 0 (enable) or address 1 (threshold) that lands in a context-switch cycle is dropped. The switch and restore values take effect instead.
- R11: A register write of 0 to address 0 stops the count at its current value. No interrupt follows, whatever ticks arrive.
- R12: A context switched out with a partial count and restored with the same settings needs the full threshold of ticks again before it expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Count one unit of elapsed work this cycle |
| engine_idle_i | input | 1 | Engine idle; holds the count |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_wr_addr_i | input | 2 | Register address: 0 enable, 1 threshold, 2 status (write one to clear) |
| reg_wr_data_i | input | CNT_W | Register write data |
| ctx_switch_i | input | 1 | Context switch pulse |
| ctx_restore_valid_i | input | 1 | Restore values accompany this switch |
| ctx_restore_enable_i | input | 1 | Incoming context enable |
| ctx_restore_thresh_i | input | CNT_W | Incoming context threshold |
| save_enable_o | output | 1 | Current enable, captured at switch-out |
| save_thresh_o | output | CNT_W | Current threshold, captured at switch-out |
| count_o | output | CNT_W | Running elapsed count |
| timeout_status_o | output | 1 | Sticky timeout status |
| irq_o | output | 1 | Timeout interrupt pulse |

## Verification
The hardest case to reach from the ports is an expiry and a status clear landing on the same edge. The stimulus reaches it by programming a small threshold, ticking to one short of it, and then issuing the final tick together with the clear write. Close behind it is a restore colliding with a register write. The bench reaches this by driving a switch, a restore and a conflicting enable or threshold write in one cycle, and then reading the result back through the save outputs. Thresholds from one to six are swept under three tick and idle patterns, so the expiry edge is hit at many different distances from the switch.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WDT_REG_ENABLE = 2'd0,
    WDT_REG_THRESH = 2'd1,
    WDT_REG_STATUS = 2'd2
  } wdt_reg_e;
endpackage

// File: rtl/wdt_ctx_regs.sv
module wdt_ctx_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ctx_switch,
  input  logic             rst_valid,
  input  logic             rst_enable,
  input  logic [CNT_W-1:0] rst_thresh,
  output logic             enable_q,
  output logic [CNT_W-1:0] thresh_q
);
  logic             enable_d;
  logic [CNT_W-1:0] thresh_d;
  logic             load_en;

  always_comb begin
    enable_d = enable_q;
    thresh_d = thresh_q;
    if (ctx_switch) begin
      // switch forces the watchdog off unless restored settings re-arm it
      enable_d = rst_valid ? rst_enable : 1'b0;
      if (rst_valid) thresh_d = rst_thresh;
    end else if (wr_en) begin
      if (wr_addr == WDT_REG_ENABLE) enable_d = wr_data[0];
      if (wr_addr == WDT_REG_THRESH) thresh_d = wr_data;
    end
  end

  assign load_en = ctx_switch | wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      thresh_q <= '0;
    end else if (load_en) begin
      enable_q <= enable_d;
      thresh_q <= thresh_d;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctx_switch,
  input  logic             enable,
  input  logic [CNT_W-1:0] thresh,
  input  logic             tick_en,
  input  logic             engine_idle,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_d;
  logic             advance;
  logic             cnt_en;

  assign advance = enable && (thresh != '0) && tick_en && !engine_idle
                   && (count_q < thresh) && !ctx_switch;
  assign expire  = advance && ((count_q + ONE) == thresh);
  assign cnt_en  = advance | ctx_switch;

  always_comb begin
    count_d = count_q;
    if (ctx_switch)   count_d = '0;
    else if (advance) count_d = count_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clear,
  output logic status_q,
  output logic irq_q
);
  logic status_d;

  // a new expiry outranks a simultaneous clear
  assign status_d = expire | (status_q & ~clear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= expire;
    end
  end
endmodule

// File: rtl/ctx_watchdog.sv
module ctx_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en_i,
  input  logic             engine_idle_i,
  input  logic             reg_wr_en_i,
  input  logic [1:0]       reg_wr_addr_i,
  input  logic [CNT_W-1:0] reg_wr_data_i,
  input  logic             ctx_switch_i,
  input  logic             ctx_restore_valid_i,
  input  logic             ctx_restore_enable_i,
  input  logic [CNT_W-1:0] ctx_restore_thresh_i,
  output logic             save_enable_o,
  output logic [CNT_W-1:0] save_thresh_o,
  output logic [CNT_W-1:0] count_o,
  output logic             timeout_status_o,
  output logic             irq_o
);
  logic             rst_meta_n, rst_sync_n;
  logic             enable_w;
  logic [CNT_W-1:0] thresh_w;
  logic             expire_w;
  logic             clear_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign clear_w = reg_wr_en_i && (reg_wr_addr_i == WDT_REG_STATUS) && reg_wr_data_i[0];

  wdt_ctx_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (reg_wr_en_i),
    .wr_addr    (reg_wr_addr_i),
    .wr_data    (reg_wr_data_i),
    .ctx_switch (ctx_switch_i),
    .rst_valid  (ctx_restore_valid_i),
    .rst_enable (ctx_restore_enable_i),
    .rst_thresh (ctx_restore_thresh_i),
    .enable_q   (enable_w),
    .thresh_q   (thresh_w)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ctx_switch  (ctx_switch_i),
    .enable      (enable_w),
    .thresh      (thresh_w),
    .tick_en     (tick_en_i),
    .engine_idle (engine_idle_i),
    .count_q     (count_o),
    .expire      (expire_w)
  );

  wdt_status u_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .expire   (expire_w),
    .clear    (clear_w),
    .status_q (timeout_status_o),
    .irq_q    (irq_o)
  );

  assign save_enable_o = enable_w;
  assign save_thresh_o = thresh_w;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en_i,
  input logic             engine_idle_i,
  input logic             ctx_switch_i,
  input logic             ctx_restore_valid_i,
  input logic             ctx_restore_enable_i,
  input logic [CNT_W-1:0] ctx_restore_thresh_i,
  input logic             save_enable_o,
  input logic [CNT_W-1:0] save_thresh_o,
  input logic [CNT_W-1:0] count_o,
  input logic             timeout_status_o,
  input logic             irq_o
);
  // R8
  switch_zeroes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_switch_i |=> (count_o == '0));

  // R9
  restore_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_switch_i && ctx_restore_valid_i) |=>
      (save_enable_o == $past(ctx_restore_enable_i)) && (save_thresh_o == $past(ctx_restore_thresh_i)));

  // R8
  switch_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_switch_i && !ctx_restore_valid_i) |=> !save_enable_o);

  // R4
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R4
  irq_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> timeout_status_o);

  // R6
  zero_thresh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_thresh_o == '0) |=> !irq_o);

  // R3
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (engine_idle_i && !ctx_switch_i) |=> $stable(count_o));

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_switch_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + CNT_W'(1)));

  // R2
  needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en_i && !ctx_switch_i) |=> $stable(count_o));
endmodule

bind ctx_watchdog wdt_checker #(.CNT_W(CNT_W)) u_wdt_chk (
  .clk                  (clk),
  .rst_n                (rst_sync_n),
  .tick_en_i            (tick_en_i),
  .engine_idle_i        (engine_idle_i),
  .ctx_switch_i         (ctx_switch_i),
  .ctx_restore_valid_i  (ctx_restore_valid_i),
  .ctx_restore_enable_i (ctx_restore_enable_i),
  .ctx_restore_thresh_i (ctx_restore_thresh_i),
  .save_enable_o        (save_enable_o),
  .save_thresh_o        (save_thresh_o),
  .count_o              (count_o),
  .timeout_status_o     (timeout_status_o),
  .irq_o                (irq_o)
);

// File: tb/sim_ctx_watchdog.sv
module sim_ctx_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic          clk, rst_n, tick, idle, wr_en, sw, rv, ren;
  logic [1:0]    wr_addr;
  logic [CW-1:0] wr_data, rth;
  logic          sv_en, stat, irq;
  logic [CW-1:0] sv_th, cnt;

  int checks = 0;
  int failures = 0;

  ctx_watchdog #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick), .engine_idle_i(idle),
    .reg_wr_en_i(wr_en), .reg_wr_addr_i(wr_addr), .reg_wr_data_i(wr_data),
    .ctx_switch_i(sw), .ctx_restore_valid_i(rv), .ctx_restore_enable_i(ren),
    .ctx_restore_thresh_i(rth), .save_enable_o(sv_en), .save_thresh_o(sv_th),
    .count_o(cnt), .timeout_status_o(stat), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; failures++;
    $display("FAIL watchdog: run hung act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    tick = 0; idle = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    sw = 0; rv = 0; ren = 0; rth = 0;
  endtask

  task automatic mmio(input int a, input int d);
    wr_en = 1; wr_addr = 2'(a); wr_data = CW'(d);
    cyc(); quiet();
  endtask

  task automatic cswitch(input logic v, input logic e, input int t);
    sw = 1; rv = v; ren = e; rth = CW'(t);
    cyc(); quiet();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
    quiet();
  endtask

  initial begin
    int ex, prv;
    logic tk, id;
    quiet();
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    repeat (4) cyc();

    // R1 reset state
    chk("R1 count", cnt, 0);
    chk("R1 status", stat, 0);
    chk("R1 irq", irq, 0);
    chk("R1 enable", sv_en, 0);
    chk("R1 thresh", sv_th, 0);

    // R2 R3 R4 R5 sweep: thresholds x tick/idle patterns
    for (int t = 1; t <= 6; t++) begin
      for (int mode = 0; mode < 3; mode++) begin
        mmio(2, 1);
        cswitch(1, 1, t);
        chk("R9 restore thresh", sv_th, t);
        chk("R8 count zero", cnt, 0);
        ex = 0;
        for (int s = 0; s < 3 * (t + 2); s++) begin
          tk = (mode == 1) ? (s % 2 == 0) : 1'b1;
          id = (mode == 2) ? (s % 3 == 2) : 1'b0;
          tick = tk; idle = id;
          cyc();
          prv = ex;
          if (tk && !id && ex < t) ex++;
          chk(id ? "R3 idle hold" : "R2 count", cnt, ex);
          chk("R4 R5 irq pulse", irq, (ex != prv && ex == t) ? 1 : 0);
          chk("R4 status", stat, (ex >= t) ? 1 : 0);
        end
        quiet();
      end
    end

    // R7 write zero has no effect, write one clears
    mmio(2, 0);
    chk("R7 write0 keeps", stat, 1);
    mmio(2, 1);
    chk("R7 w1c", stat, 0);

    // R6 zero threshold never fires
    cswitch(1, 1, 0);
    ticks(20);
    chk("R6 count", cnt, 0);
    chk("R6 status", stat, 0);

    // R9 save port shows outgoing values; R8 switch without restore
    cswitch(1, 1, 9);
    ticks(4);
    sw = 1; rv = 0;
    #1;
    chk("R9 save enable", sv_en, 1);
    chk("R9 save thresh", sv_th, 9);
    cyc(); quiet();
    chk("R8 disabled", sv_en, 0);
    chk("R8 thresh kept", sv_th, 9);
    chk("R8 count zero", cnt, 0);
    ticks(5);
    chk("R8 stays off", cnt, 0);
    mmio(0, 1);
    ticks(3);
    chk("R8 sw enable", cnt, 3);

    // R11 software disable holds count
    mmio(0, 0);
    ticks(10);
    chk("R11 hold", cnt, 3);
    chk("R11 no irq", stat, 0);

    // R10 switch beats same-cycle writes
    sw = 1; rv = 1; ren = 0; rth = 5; wr_en = 1; wr_addr = 0; wr_data = 1;
    cyc(); quiet();
    chk("R10 enable", sv_en, 0);
    sw = 1; rv = 1; ren = 1; rth = 4; wr_en = 1; wr_addr = 1; wr_data = 7;
    cyc(); quiet();
    chk("R10 thresh", sv_th, 4);

    // R12 resubmit gets full allowance
    ticks(3);
    chk("R12 partial", cnt, 3);
    cswitch(1, 1, 4);
    ticks(3);
    chk("R12 no expiry", stat, 0);
    ticks(1);
    chk("R12 full expiry", stat, 1);

    // R7 expiry and clear same cycle: set wins
    mmio(2, 1);
    cswitch(1, 1, 2);
    ticks(1);
    tick = 1; wr_en = 1; wr_addr = 2; wr_data = 1;
    cyc(); quiet();
    chk("R7 set wins", stat, 1);
    chk("R7 irq", irq, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule